// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Descriptor Sequencer

This block is the control front end of an interrupt-driven data mover. It watches a bank of interrupt sources. Each source has a pending flag and a two-bit routing code. A pending source whose code asks for a hardware transfer is taken by the sequencer. A pending source whose code asks for the processor is passed to the processor as an interrupt line.

For each accepted source, the sequencer first reads one longword from a vector table. The table entry sits at a programmable base plus four bytes per vector number. The value it reads is the descriptor pointer, and its two low bits are always forced to zero. The sequencer then fetches a descriptor of three longwords (packed layout) or four longwords (extended layout) over a valid/ready read port. It unpacks the mode bytes, addresses and counts, and presents them to the datapath with a one-cycle start pulse.

When the datapath reports done, the sequencer either follows a chained descriptor placed directly behind the current one, or finishes. To finish, it issues a one-cycle clear strobe that names the source. The interrupt controller then drops that source's flag and resets its routing code, so the next request from that source goes to the processor.

Top module: `xfer_desc_seq`

## Requirements
- R1: A source with its flag set and routing code 2'b01 starts the sequencer. A source with its flag set and code 2'b00 raises its `cpu_irq` bit and starts no read. Codes 2'b10 and 2'b11 do neither.
- R2: When several routed sources are pending, the sequencer serves the one with the lowest index first.
- R3: The first read for an accepted source is at address `tbl_base + 4*vector`.
- R4: The pointer read from the table is used with bits [1:0] forced to 00. Every descriptor read address therefore has its two low bits at zero.
- R5: With `short_mode`=1 when the request is accepted, three longwords are read at pointer+0, +4 and +8. Word 0 holds mode A in [31:24] and the source address in [23:0]. Word 1 holds mode B in [31:24] and the destination address in [23:0]. Word 2 holds count A in [31:16] and count B in [15:0]. Each 24-bit address is widened to 32 bits by copying bit 23 into the upper byte.
- R6: With `short_mode`=0, four longwords are read at pointer+0 through +12. Word 0 holds mode A in [31:24] and mode B in [23:16]. Word 1 holds the 32-bit source address and word 2 the 32-bit destination address. Word 3 holds count A in [31:16] and count B in [15:0].
- R7: If bit 7 of mode B is set, then after `xfer_done` the next descriptor is fetched at the current pointer +12 (packed) or +16 (extended). No further vector read is made.
- R8: After `xfer_done` for a descriptor whose mode B bit 7 is clear, `clr_strobe` is high for exactly one cycle with `clr_vec` naming the served source.
- R9: `busy` rises in the cycle after a request is accepted. It stays high through the clear-strobe cycle and is low in the cycle after it.
- R10: A read request is held, with `rd_addr` unchanged, until `rd_ready` accepts it. The response is taken on a later cycle with `rd_resp_valid`.
- R11: `xfer_start` is a one-cycle pulse that follows the last descriptor word. The unpacked fields are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flag | input | NUM_SRC | Pending flag per source |
| irq_route | input | 2*NUM_SRC | Two-bit routing code per source, source i at [2i+1:2i] |
| cpu_irq | output | NUM_SRC | Pending requests routed to the processor |
| tbl_base | input | 32 | Vector table base address |
| short_mode | input | 1 | 1 selects packed three-longword descriptors |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| xfer_start | output | 1 | Start pulse to the datapath |
| xfer_mode_a | output | 8 | Mode byte A |
| xfer_mode_b | output | 8 | Mode byte B |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_cnt_a | output | 16 | Count A |
| xfer_cnt_b | output | 16 | Count B |
| xfer_done | input | 1 | Datapath finished the current descriptor |
| clr_strobe | output | 1 | Clear flag and routing code of source `clr_vec` |
| clr_vec | output | $clog2(NUM_SRC) | Source to clear |
| busy | output | 1 | Sequencer is serving a source |

## Verification
The bench builds the block with NUM_SRC=8. This makes vector 7 the top entry of the priority picker, and it places the table entries for vectors 0 through 7 within one short range of addresses above the base. With eight sources, a three-way simultaneous request spanning low, middle and top indices can be served in full. Packed and extended chains of two descriptors also fit, as does a table pointer with nonzero low bits. Read acceptance and response latency vary by a pseudo-random sequence, so the hold rule is exercised under back-pressure.

// File: rtl/xds_pkg.sv
package xds_pkg;

  localparam int DATA_W      = 32;
  localparam int SHORT_WORDS = 3;
  localparam int FULL_WORDS  = 4;
  localparam int WIDX_W      = $clog2(FULL_WORDS);
  localparam int CHAIN_BIT   = 7;

  localparam logic [1:0] ROUTE_CPU = 2'b00;
  localparam logic [1:0] ROUTE_DMA = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC_REQ,
    ST_VEC_RSP,
    ST_DSC_REQ,
    ST_DSC_RSP,
    ST_XFER,
    ST_XWAIT,
    ST_CLEAR
  } seq_state_e;

  typedef struct packed {
    logic [7:0]        mode_a;
    logic [7:0]        mode_b;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] dst;
    logic [15:0]       cnt_a;
    logic [15:0]       cnt_b;
  } desc_t;

endpackage

// File: rtl/xds_pick.sv
module xds_pick #(
  parameter int NUM_SRC = 16,
  localparam int VW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               hit,
  output logic [VW-1:0]      idx
);

  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = VW'(i);
    end
  end

endmodule

// File: rtl/xds_unpack.sv
module xds_unpack
  import xds_pkg::*;
(
  input  logic                         packed_fmt,
  input  logic [FULL_WORDS-1:0][DATA_W-1:0] words,
  output desc_t                        desc
);

  function automatic logic [DATA_W-1:0] widen24(input logic [23:0] a);
    return {{(DATA_W-24){a[23]}}, a};
  endfunction

  always_comb begin
    if (packed_fmt) begin
      desc.mode_a = words[0][31:24];
      desc.src    = widen24(words[0][23:0]);
      desc.mode_b = words[1][31:24];
      desc.dst    = widen24(words[1][23:0]);
      desc.cnt_a  = words[2][31:16];
      desc.cnt_b  = words[2][15:0];
    end else begin
      desc.mode_a = words[0][31:24];
      desc.mode_b = words[0][23:16];
      desc.src    = words[1];
      desc.dst    = words[2];
      desc.cnt_a  = words[3][31:16];
      desc.cnt_b  = words[3][15:0];
    end
  end

endmodule

// File: rtl/xfer_desc_seq.sv
module xfer_desc_seq
  import xds_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int VW = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_flag,
  input  logic [2*NUM_SRC-1:0] irq_route,
  output logic [NUM_SRC-1:0]   cpu_irq,
  input  logic [31:0]          tbl_base,
  input  logic                 short_mode,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [31:0]          rd_addr,
  input  logic                 rd_resp_valid,
  input  logic [31:0]          rd_resp_data,
  output logic                 xfer_start,
  output logic [7:0]           xfer_mode_a,
  output logic [7:0]           xfer_mode_b,
  output logic [31:0]          xfer_src,
  output logic [31:0]          xfer_dst,
  output logic [15:0]          xfer_cnt_a,
  output logic [15:0]          xfer_cnt_b,
  input  logic                 xfer_done,
  output logic                 clr_strobe,
  output logic [VW-1:0]        clr_vec,
  output logic                 busy
);

  localparam logic [31:0] STEP_SHORT = 32'(SHORT_WORDS * 4);
  localparam logic [31:0] STEP_FULL  = 32'(FULL_WORDS * 4);

  seq_state_e              state_q, state_d;
  logic [VW-1:0]           vec_q;
  logic                    short_q;
  logic [31:0]             base_q, base_d;
  logic [WIDX_W-1:0]       word_q, word_d;
  logic                    vec_ld, base_ld, word_ld;
  logic [FULL_WORDS-1:0][DATA_W-1:0] words_q;
  logic [NUM_SRC-1:0]      routed;
  logic                    pick_hit;
  logic [VW-1:0]           pick_idx;
  logic [WIDX_W-1:0]       last_word;
  logic                    take_word;
  desc_t                   desc;

  // routing decode per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign routed[g]  = irq_flag[g] && (irq_route[2*g +: 2] == ROUTE_DMA);
    assign cpu_irq[g] = irq_flag[g] && (irq_route[2*g +: 2] == ROUTE_CPU);
  end

  xds_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req (routed),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  xds_unpack u_unpack (
    .packed_fmt (short_q),
    .words      (words_q),
    .desc       (desc)
  );

  assign last_word = short_q ? WIDX_W'(SHORT_WORDS - 1) : WIDX_W'(FULL_WORDS - 1);
  assign take_word = (state_q == ST_DSC_RSP) && rd_resp_valid;

  // next-state logic
  always_comb begin
    state_d = state_q;
    vec_ld  = 1'b0;
    base_ld = 1'b0;
    base_d  = base_q;
    word_ld = 1'b0;
    word_d  = word_q;
    case (state_q)
      ST_IDLE: begin
        if (pick_hit) begin
          vec_ld  = 1'b1;
          state_d = ST_VEC_REQ;
        end
      end
      ST_VEC_REQ: if (rd_ready) state_d = ST_VEC_RSP;
      ST_VEC_RSP: begin
        if (rd_resp_valid) begin
          base_ld = 1'b1;
          base_d  = {rd_resp_data[31:2], 2'b00};
          word_ld = 1'b1;
          word_d  = '0;
          state_d = ST_DSC_REQ;
        end
      end
      ST_DSC_REQ: if (rd_ready) state_d = ST_DSC_RSP;
      ST_DSC_RSP: begin
        if (rd_resp_valid) begin
          if (word_q == last_word) begin
            state_d = ST_XFER;
          end else begin
            word_ld = 1'b1;
            word_d  = word_q + WIDX_W'(1);
            state_d = ST_DSC_REQ;
          end
        end
      end
      ST_XFER: state_d = ST_XWAIT;
      ST_XWAIT: begin
        if (xfer_done) begin
          if (desc.mode_b[CHAIN_BIT]) begin
            base_ld = 1'b1;
            base_d  = base_q + (short_q ? STEP_SHORT : STEP_FULL);
            word_ld = 1'b1;
            word_d  = '0;
            state_d = ST_DSC_REQ;
          end else begin
            state_d = ST_CLEAR;
          end
        end
      end
      ST_CLEAR: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      short_q <= 1'b0;
      base_q  <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (vec_ld) begin
        vec_q   <= pick_idx;
        short_q <= short_mode;
      end
      if (base_ld) base_q <= base_d;
      if (word_ld) word_q <= word_d;
    end
  end

  // descriptor word capture, one register per longword slot
  for (genvar k = 0; k < FULL_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[k] <= '0;
      end else if (take_word && (word_q == WIDX_W'(k))) begin
        words_q[k] <= rd_resp_data;
      end
    end
  end

  // outputs
  always_comb begin
    if (state_q == ST_VEC_REQ) rd_addr = tbl_base + (32'(vec_q) << 2);
    else                       rd_addr = base_q + (32'(word_q) << 2);
  end

  assign rd_valid    = (state_q == ST_VEC_REQ) || (state_q == ST_DSC_REQ);
  assign xfer_start  = (state_q == ST_XFER);
  assign clr_strobe  = (state_q == ST_CLEAR);
  assign clr_vec     = vec_q;
  assign busy        = (state_q != ST_IDLE);
  assign xfer_mode_a = desc.mode_a;
  assign xfer_mode_b = desc.mode_b;
  assign xfer_src    = desc.src;
  assign xfer_dst    = desc.dst;
  assign xfer_cnt_a  = desc.cnt_a;
  assign xfer_cnt_b  = desc.cnt_b;

endmodule

// File: rtl/xds_chk.sv
module xds_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] tbl_base,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        xfer_start,
  input logic        clr_strobe,
  input logic        busy
);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R4
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && (tbl_base[1:0] == 2'b00) |-> rd_addr[1:0] == 2'b00);

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  // R8
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |=> !clr_strobe);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |-> busy ##1 !busy);

  // R9
  busy_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || xfer_start) |-> busy);

endmodule

bind xfer_desc_seq xds_chk u_xds_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tbl_base   (tbl_base),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .xfer_start (xfer_start),
  .clr_strobe (clr_strobe),
  .busy       (busy)
);

// File: tb/xfer_desc_seq_bench.sv
module xfer_desc_seq_bench;

  localparam int N    = 8;
  localparam int VW   = $clog2(N);
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  flag_r = '0;
  logic [2*N-1:0] route_r = '0;
  logic [N-1:0]  cpu_irq;
  logic          short_r = 1'b0;
  logic          rd_valid, rd_ready = 1'b0;
  logic [31:0]   rd_addr;
  logic          resp_valid = 1'b0;
  logic [31:0]   resp_data = '0;
  logic          xfer_start;
  logic [7:0]    mode_a, mode_b;
  logic [31:0]   src, dst;
  logic [15:0]   cnt_a, cnt_b;
  logic          xfer_done = 1'b0;
  logic          clr_strobe;
  logic [VW-1:0] clr_vec;
  logic          busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0]  mem [logic [31:0]];
  logic [31:0]  exp_rd [$];
  logic [111:0] exp_xf [$];
  int           exp_cl [$];

  always #10 clk = ~clk;

  xfer_desc_seq #(.NUM_SRC(N)) u_xfer_desc_seq (
    .clk(clk), .rst_n(rst_n), .irq_flag(flag_r), .irq_route(route_r),
    .cpu_irq(cpu_irq), .tbl_base(BASE), .short_mode(short_r),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(resp_valid), .rd_resp_data(resp_data),
    .xfer_start(xfer_start), .xfer_mode_a(mode_a), .xfer_mode_b(mode_b),
    .xfer_src(src), .xfer_dst(dst), .xfer_cnt_a(cnt_a), .xfer_cnt_b(cnt_b),
    .xfer_done(xfer_done), .clr_strobe(clr_strobe), .clr_vec(clr_vec),
    .busy(busy)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wid(input logic [23:0] a);
    return {{8{a[23]}}, a};
  endfunction

  // driver side: load memory and queue expectations
  task automatic exp_vec(int v, logic [31:0] ptr);
    mem[BASE + 32'(4*v)] = ptr;
    exp_rd.push_back(BASE + 32'(4*v));
  endtask

  task automatic exp_desc(logic [31:0] a, bit shrt, logic [31:0] w0, logic [31:0] w1,
                          logic [31:0] w2, logic [31:0] w3);
    mem[a] = w0; mem[a+4] = w1; mem[a+8] = w2;
    exp_rd.push_back(a); exp_rd.push_back(a+4); exp_rd.push_back(a+8);
    if (shrt) begin
      exp_xf.push_back({w0[31:24], w1[31:24], wid(w0[23:0]), wid(w1[23:0]), w2[31:16], w2[15:0]});
    end else begin
      mem[a+12] = w3;
      exp_rd.push_back(a+12);
      exp_xf.push_back({w0[31:24], w0[23:16], w1, w2, w3[31:16], w3[15:0]});
    end
  endtask

  task automatic raise(int v, logic [1:0] code);
    route_r[2*v +: 2] = code;
    flag_r[v] = 1'b1;
  endtask

  task automatic wait_quiet();
    int n = 0;
    while ((exp_rd.size() != 0 || exp_xf.size() != 0 || exp_cl.size() != 0 || busy) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    check("R8 queues drained", 128'(exp_rd.size() + exp_xf.size() + exp_cl.size()), 128'(0));
  endtask

  // memory responder and read monitor
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic        last_v = 1'b0;
    logic [31:0] last_a = '0;
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      resp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          resp_valid = 1'b1;
          resp_data = mem.exists(paddr) ? mem[paddr] : 32'h0;
          pend = 0;
        end else cnt--;
      end
      if (rd_ready && last_v && rst_n) begin
        if (exp_rd.size() == 0) check("R1 unexpected read", 128'(last_a), 128'hFFFF_FFFF_FFFF);
        else check("R3/R5/R6/R7 read address", 128'(last_a), 128'(exp_rd.pop_front()));
        pend = 1; cnt = int'(lfsr[1:0] % 3); paddr = last_a;
        rd_ready = 1'b0;
      end else begin
        rd_ready = !pend && lfsr[3];
      end
      last_v = rd_valid; last_a = rd_addr;
    end
  end

  // transfer monitor and done generator
  initial begin
    int dcnt = -1;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) begin xfer_done = 1'b1; dcnt = -1; end
      end
      if (xfer_start) begin
        if (exp_xf.size() == 0) check("R11 unexpected start", 128'(1), 128'(0));
        else check("R5/R6/R11 fields", 128'({mode_a, mode_b, src, dst, cnt_a, cnt_b}),
                   128'(exp_xf.pop_front()));
        dcnt = 1 + (checks % 3);
      end
    end
  end

  // interrupt controller model: clear on strobe
  initial begin
    forever begin
      @(negedge clk);
      if (clr_strobe) begin
        if (exp_cl.size() == 0) check("R8 unexpected clear", 128'(clr_vec), 128'hFF);
        else check("R8 clear vector", 128'(clr_vec), 128'(exp_cl.pop_front()));
        flag_r[clr_vec] = 1'b0;
        route_r[2*clr_vec +: 2] = 2'b00;
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset busy", 128'(busy), 128'(0));
    check("R10 reset rd_valid", 128'(rd_valid), 128'(0));
    check("R11 reset start", 128'(xfer_start), 128'(0));
    check("R8 reset clear", 128'(clr_strobe), 128'(0));

    // R1: processor routing and unused codes
    raise(2, 2'b00);
    raise(5, 2'b11);
    repeat (8) @(negedge clk);
    check("R1 cpu_irq", 128'(cpu_irq), 128'(8'b0000_0100));
    check("R1 no start for cpu/unused codes", 128'(busy), 128'(0));
    flag_r = '0; route_r = '0;
    @(negedge clk);

    // R6 + R4: extended single, pointer with low bits set
    short_r = 1'b0;
    exp_vec(3, 32'h0000_2003);
    exp_desc(32'h2000, 0, 32'h1205_0000, 32'hAABB_CCDD, 32'h1122_3344, 32'h0010_0020);
    exp_cl.push_back(3);
    raise(3, 2'b01);
    @(negedge clk);
    check("R9 busy after accept", 128'(busy), 128'(1));
    wait_quiet();
    check("R8 route cleared", 128'(route_r[7:6]), 128'(0));

    // R5: packed single, negative and positive addresses
    short_r = 1'b1;
    exp_vec(1, 32'h0000_3001);
    exp_desc(32'h3000, 1, 32'h4480_0010, 32'h0701_2345, 32'h0003_0004, 32'h0);
    exp_cl.push_back(1);
    raise(1, 2'b01);
    wait_quiet();

    // R7: extended chain, second descriptor at +16
    short_r = 1'b0;
    exp_vec(6, 32'h0000_4000);
    exp_desc(32'h4000, 0, 32'h0180_0000, 32'h1111_0000, 32'h2222_0000, 32'h0001_0002);
    exp_desc(32'h4010, 0, 32'h0200_0000, 32'h3333_0000, 32'h4444_0000, 32'h0003_0004);
    exp_cl.push_back(6);
    raise(6, 2'b01);
    wait_quiet();

    // R7: packed chain, second descriptor at +12
    short_r = 1'b1;
    exp_vec(0, 32'h0000_5000);
    exp_desc(32'h5000, 1, 32'h09FF_FFFE, 32'h8000_0100, 32'h0005_0006, 32'h0);
    exp_desc(32'h500C, 1, 32'h0A00_0200, 32'h0B80_0000, 32'h0007_0008, 32'h0);
    exp_cl.push_back(0);
    raise(0, 2'b01);
    wait_quiet();

    // R2: three simultaneous requests, lowest first
    short_r = 1'b0;
    exp_vec(2, 32'h0000_6000);
    exp_desc(32'h6000, 0, 32'h2100_0000, 32'h0000_6100, 32'h0000_6200, 32'h0002_0002);
    exp_cl.push_back(2);
    exp_vec(4, 32'h0000_7000);
    exp_desc(32'h7000, 0, 32'h4100_0000, 32'h0000_7100, 32'h0000_7200, 32'h0004_0004);
    exp_cl.push_back(4);
    exp_vec(7, 32'h0000_8000);
    exp_desc(32'h8000, 0, 32'h7100_0000, 32'h0000_8100, 32'h0000_8200, 32'h0007_0007);
    exp_cl.push_back(7);
    raise(7, 2'b01); raise(4, 2'b01); raise(2, 2'b01);
    wait_quiet();
    check("R2 all flags cleared", 128'(flag_r), 128'(0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule